// File: doc/BRIEF.md
# External Oscillator Failure Supervisor

This block watches an external oscillator for loss of clock and, when the clock stops, runs a fixed recovery sequence. A flop divides the external clock by two. Its output is synchronised into the reference clock domain, where the internal RC clock drives the block. A timer measures how many reference cycles pass between toggles. When too many cycles pass with no toggle, the block declares a failure.

The recovery depends on what the master clock is at that moment. If the external source is the master, the block does all of the following:
- forces the master selection and status back to the internal code;
- forces the internal-RC divider to its slowest setting;
- holds the internal RC enabled;
- turns the external oscillator off;
- raises a sticky auxiliary flag.

If the external source is not the master, the block only turns the external oscillator off and raises the detection flag.

A small write port sets the supervisor enable, which can be written once only, and the interrupt enable. Through the same port, software clears the detection flag and writes the internal-RC divider field. The surrounding clock controller feeds in the current master code, the external-enable state and the crystal-mode condition.

Top module: `osc_fail_sup`

## Requirements
- R1: Only the first write to the control word (address 0) after reset sets the supervisor enable, from bit 0 of that write. Later writes leave `sup_en` unchanged, whether they carry 0 or 1.
- R2: No failure is declared unless all four conditions hold: `sup_en` is 1, `ext_en_in` is 1, `crystal_mode` is 1, and the detector has not tripped since `ext_en_in` was last low.
- R3: When armed, a failure is declared after 8 consecutive reference cycles with no synchronised toggle of the divided external clock. An external clock whose toggles arrive less than 8 reference cycles apart never causes a failure.
- R4: A failure while `cur_master` equals 0xB4 (external) does all of the following in the next cycle: sets `det_flag` and `aux_flag`; pulses `sel_force` for one cycle, with `sel_code` equal to 0xE1; sets `hsi_div` to 2'b11 (divide by 8); pulses `ext_force_off` for one cycle; and drives `hsi_force_on` high.
- R5: Once set, `aux_flag` and `hsi_force_on` stay high until reset, even after the detection flag is cleared.
- R6: A failure while the master is not external pulses `ext_force_off` and sets `det_flag`, and does nothing else: there is no `sel_force` pulse, `aux_flag` stays 0 and `hsi_div` is unchanged.
- R7: `irq` equals `det_flag` AND the interrupt enable (control bit 1). Writing 0 to control bit 2 clears `det_flag`; writing 1 there has no effect.
- R8: Writes to the divider field (address 1, bits 1:0) are ignored while `det_flag` is 1 and take effect when it is 0. The reset value of `hsi_div` is 2'b11.
- R9: After a failure, the detector stays disarmed while `ext_en_in` remains 1. It re-arms only after `ext_en_in` has been seen low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from the internal RC |
| rst_n | input | 1 | Active-low asynchronous reset |
| xclk | input | 1 | External oscillator clock being supervised |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: control word, 1: divider field |
| wr_data | input | 8 | Write data |
| cur_master | input | 8 | Current master-source status code |
| ext_en_in | input | 1 | External oscillator enabled |
| crystal_mode | input | 1 | External source is configured as a crystal |
| sup_en | output | 1 | Supervisor enable (write once) |
| det_flag | output | 1 | Failure detected flag |
| aux_flag | output | 1 | Auxiliary internal source forced; only reset clears it |
| irq | output | 1 | Interrupt request |
| sel_force | output | 1 | One-cycle pulse that forces the master selection and status |
| sel_code | output | 8 | Code to force into the selection and status (0xE1) |
| hsi_div | output | 2 | Internal-RC divider field |
| hsi_force_on | output | 1 | Holds the internal RC enabled |
| ext_force_off | output | 1 | One-cycle pulse that clears the external enable |

## Verification
The assertions check, on every cycle, the following properties:
- the enable and auxiliary flags are sticky;
- no failure follows a seen toggle directly;
- the master-case failure produces the full set of forced outputs on the next cycle;
- the divider holds while a detection is pending;
- a non-master failure never forces the selection.

Only the bench's scenarios can show the rest:
- the exact 8-cycle timeout against a stopped or slow external clock;
- the write-once lockout when the first write carries 0;
- the interaction between clearing the detection flag and re-enabling the oscillator that re-arms the detector.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;
  localparam logic [7:0] SRC_INT_CODE = 8'hE1;
  localparam logic [7:0] SRC_EXT_CODE = 8'hB4;
  localparam logic [1:0] DIV_SLOWEST  = 2'b11;
  localparam int         CTRL_EN_BIT  = 0;
  localparam int         CTRL_IE_BIT  = 1;
  localparam int         CTRL_DET_BIT = 2;
  localparam logic       ADDR_CTRL    = 1'b0;
  localparam logic       ADDR_DIV     = 1'b1;

  // True on the last quiet cycle that still fits in the window.
  function automatic logic window_spent(input int unsigned quiet, input int unsigned limit);
    return (quiet + 1) >= limit;
  endfunction
endpackage

// File: rtl/osc_edge_mon.sv
module osc_edge_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xclk,
  output logic ext_edge
);
  logic              half_q;
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge xclk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], half_q};
  end

  assign ext_edge = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/osc_loss_timer.sv
module osc_loss_timer
  import osc_sup_pkg::*;
#(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic ext_edge,
  output logic loss
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] quiet_q;

  assign loss = armed && !ext_edge && window_spent(int'(quiet_q), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        quiet_q <= '0;
    else if (!armed || ext_edge || loss) quiet_q <= '0;
    else                               quiet_q <= quiet_q + 1'b1;
  end

  AST_NO_LOSS_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ext_edge) |=> !loss); // R3
endmodule

// File: rtl/osc_sup_regs.sv
module osc_sup_regs
  import osc_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       loss,
  input  logic       master_is_ext,
  input  logic       ext_en_in,
  output logic       sup_en,
  output logic       irq_en,
  output logic       det,
  output logic       aux,
  output logic [1:0] hsi_div,
  output logic       sel_force,
  output logic       ext_off,
  output logic       tripped
);
  logic en_locked;
  logic ctrl_wr, div_wr, det_clr, master_fail;

  assign ctrl_wr     = wr_en && (wr_addr == ADDR_CTRL);
  assign div_wr      = wr_en && (wr_addr == ADDR_DIV);
  assign det_clr     = ctrl_wr && !wr_data[CTRL_DET_BIT];
  assign master_fail = loss && master_is_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_en <= 1'b0; en_locked <= 1'b0; irq_en <= 1'b0;
    end else if (ctrl_wr) begin
      irq_en <= wr_data[CTRL_IE_BIT];
      if (!en_locked) begin
        sup_en    <= wr_data[CTRL_EN_BIT];
        en_locked <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det <= 1'b0; aux <= 1'b0; tripped <= 1'b0;
      sel_force <= 1'b0; ext_off <= 1'b0;
    end else begin
      sel_force <= master_fail;
      ext_off   <= loss;
      if (loss)         det <= 1'b1;
      else if (det_clr) det <= 1'b0;
      if (master_fail)  aux <= 1'b1;
      if (loss)            tripped <= 1'b1;
      else if (!ext_en_in) tripped <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hsi_div <= DIV_SLOWEST;
    else if (master_fail)      hsi_div <= DIV_SLOWEST;
    else if (div_wr && !det)   hsi_div <= wr_data[1:0];
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sup_en |=> sup_en); // R1
  AST_AUX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    aux |=> aux); // R5
  AST_MASTER_FAIL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    master_fail |=> (det && aux && sel_force && ext_off && hsi_div == DIV_SLOWEST)); // R4
  AST_OTHER_FAIL_NO_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (loss && !master_is_ext) |=> (ext_off && det && !sel_force)); // R6
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (det && !loss) |=> $stable(hsi_div)); // R8
endmodule

// File: rtl/osc_fail_sup.sv
module osc_fail_sup
  import osc_sup_pkg::*;
#(
  parameter int LIMIT       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xclk,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] cur_master,
  input  logic       ext_en_in,
  input  logic       crystal_mode,
  output logic       sup_en,
  output logic       det_flag,
  output logic       aux_flag,
  output logic       irq,
  output logic       sel_force,
  output logic [7:0] sel_code,
  output logic [1:0] hsi_div,
  output logic       hsi_force_on,
  output logic       ext_force_off
);
  logic ext_edge, loss, armed, tripped, irq_en, master_is_ext;

  assign master_is_ext = (cur_master == SRC_EXT_CODE);
  assign armed         = sup_en && ext_en_in && crystal_mode && !tripped;

  osc_edge_mon #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .xclk(xclk), .ext_edge(ext_edge));

  osc_loss_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .armed(armed), .ext_edge(ext_edge), .loss(loss));

  osc_sup_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .loss(loss), .master_is_ext(master_is_ext), .ext_en_in(ext_en_in),
    .sup_en(sup_en), .irq_en(irq_en), .det(det_flag), .aux(aux_flag),
    .hsi_div(hsi_div), .sel_force(sel_force), .ext_off(ext_force_off),
    .tripped(tripped));

  assign irq          = det_flag && irq_en;
  assign sel_code     = SRC_INT_CODE;
  assign hsi_force_on = aux_flag;

  AST_NO_LOSS_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_en || !crystal_mode || !ext_en_in) |-> !loss); // R2
  AST_REARM_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && ext_en_in) |=> !loss); // R9
endmodule

// File: tb/osc_fail_sup_bench.sv
`timescale 1ns/1ps
module osc_fail_sup_bench;
  logic clk = 0, rst_n = 0, xclk = 0;
  logic wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0, cur_master = 8'hE1;
  logic ext_en_in = 0, crystal_mode = 0;
  logic sup_en, det_flag, aux_flag, irq, sel_force, hsi_force_on, ext_force_off;
  logic [7:0] sel_code;
  logic [1:0] hsi_div;

  int checks = 0, errors = 0, cycles = 0;
  int n_sel = 0, n_off = 0;
  int xhalf = 7;
  bit xrun = 0;

  always #2.5 clk = ~clk;
  always begin #(xhalf); if (xrun) xclk = ~xclk; end
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (sel_force) n_sel <= n_sel + 1;
    if (ext_force_off) n_off <= n_off + 1;
  end

  osc_fail_sup u_osc_fail_sup (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; xrun = 0; ext_en_in = 0; crystal_mode = 0;
    cur_master = 8'hE1; xhalf = 7;
    tick(2); rst_n = 1; tick(1);
  endtask

  task automatic t_reset;
    chk("R1 reset sup_en", sup_en, 0);
    chk("R7 reset det", det_flag, 0);
    chk("R5 reset aux", aux_flag, 0);
    chk("R8 reset div", hsi_div, 3);
    chk("R7 reset irq", irq, 0);
  endtask

  task automatic t_write_once;
    do_reset(); wr(0, 8'h00); wr(0, 8'h01);
    chk("R1 first write 0 locks", sup_en, 0);
    do_reset(); wr(0, 8'h01); wr(0, 8'h00);
    chk("R1 enable sticks", sup_en, 1);
  endtask

  task automatic t_unarmed;
    do_reset(); wr(0, 8'h01); ext_en_in = 1; crystal_mode = 0; tick(30);
    chk("R2 user clock mode not armed", det_flag, 0);
    ext_en_in = 0; crystal_mode = 1; tick(30);
    chk("R2 external off not armed", det_flag, 0);
  endtask

  task automatic t_timing;
    do_reset(); wr(0, 8'h01); ext_en_in = 1; crystal_mode = 1; xhalf = 7; xrun = 1;
    tick(200);
    chk("R3 running clock no failure", det_flag, 0);
    xrun = 0; tick(8);
    chk("R3 no failure before 8 quiet cycles", det_flag, 0);
    tick(8);
    chk("R3 failure after quiet window", det_flag, 1);
    do_reset(); wr(0, 8'h01); ext_en_in = 1; crystal_mode = 1; xhalf = 60; xrun = 1;
    tick(80);
    chk("R3 slow clock declared failed", det_flag, 1);
  endtask

  task automatic t_master_fail;
    int s0, o0;
    do_reset(); wr(0, 8'h03); wr(1, 8'h00);
    chk("R8 div write when clear", hsi_div, 0);
    cur_master = 8'hB4; ext_en_in = 1; crystal_mode = 1; xrun = 1; tick(40);
    s0 = n_sel; o0 = n_off; xrun = 0; tick(20);
    chk("R4 det set", det_flag, 1);
    chk("R4 aux set", aux_flag, 1);
    chk("R4 sel pulse count", n_sel - s0, 1);
    chk("R4 sel code", sel_code, 8'hE1);
    chk("R4 ext off pulse", n_off - o0, 1);
    chk("R4 div forced /8", hsi_div, 3);
    chk("R4 hsi forced on", hsi_force_on, 1);
    chk("R7 irq with enable", irq, 1);
    ext_en_in = 0; cur_master = 8'hE1;
    wr(0, 8'h06); tick(1);
    chk("R7 det kept by writing 1", det_flag, 1);
    wr(0, 8'h02); tick(1);
    chk("R7 det cleared", det_flag, 0);
    chk("R7 irq low", irq, 0);
    chk("R5 aux survives clear", aux_flag, 1);
    chk("R5 hsi still forced", hsi_force_on, 1);
    wr(1, 8'h01);
    chk("R8 div write after clear", hsi_div, 1);
  endtask

  task automatic t_other_fail;
    int s0, o0;
    do_reset(); wr(0, 8'h01); wr(1, 8'h02);
    cur_master = 8'hE1; ext_en_in = 1; crystal_mode = 1; xrun = 1; tick(40);
    s0 = n_sel; o0 = n_off; xrun = 0; tick(20);
    chk("R6 det set", det_flag, 1);
    chk("R6 no sel pulse", n_sel - s0, 0);
    chk("R6 ext off pulse", n_off - o0, 1);
    chk("R6 aux stays 0", aux_flag, 0);
    chk("R6 div unchanged", hsi_div, 2);
    chk("R7 no irq without enable", irq, 0);
    wr(1, 8'h00);
    chk("R8 div write ignored", hsi_div, 2);
    // R9: external enable kept high, detector must stay disarmed
    wr(0, 8'h00); tick(40);
    chk("R9 stays disarmed", det_flag, 0);
    ext_en_in = 0; tick(2); ext_en_in = 1; tick(20);
    chk("R9 re-armed after re-enable", det_flag, 1);
  endtask

  initial begin
    tick(1); rst_n = 1; tick(1);
    t_reset();
    t_write_once();
    t_unarmed();
    t_timing();
    t_master_fail();
    t_other_fail();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule